// File: doc/BRIEF.md
# Shared Interrupt Node Request Generator

This block forms the single request line that one interrupt vector presents to the CPU when several event sources share that vector. Each source owns a status flag, which a one-cycle event pulse sets and a software strobe clears. A source may or may not have its own enable bit; the build-time mask `SRC_HAS_EN` says which do. A flag counts towards the node (it is "qualified") when its source enable is set, or always if the source has no enable of its own, and only while the node enable is high.

The pending request is edge-triggered. It is set when the OR of the qualified flags rises. It is dropped when the CPU acknowledges the node, when the node enable is low, or as soon as no qualified flag is left set. Because of that last rule, servicing and clearing every enabled flag removes the request, so the CPU never vectors again to a node with nothing to do. A flag that stays set through service holds the OR high. Further events on that flag then raise no new request until the OR has fallen and risen again.

Top module: `isr_shared_node`

## Requirements
- R1: An event pulse on source i sets flag i on the next clock edge (flags_o bit i reads 1 one cycle later). If a clear strobe arrives in the same cycle, the event wins.
- R2: A clear strobe on source i, with no event on i in that cycle, clears flag i on the next clock edge.
- R3: With the node enable high, a rising edge of the qualified-flag OR sets req_o one clock after the flag itself appears, which is two cycles after the event pulse.
- R4: A flag whose source has an individual enable (mask `SRC_HAS_EN` bit set; default 4'b0011, so sources 0 and 1) and whose src_en_i bit is 0 is not qualified and raises no request.
- R5: A flag whose source has no individual enable (default sources 2 and 3) is qualified whenever node_en_i is high, whatever its src_en_i bit is.
- R6: An acknowledge clears req_o on the next clock edge. When an acknowledge and a rising edge fall in the same cycle, the acknowledge wins.
- R7: When every qualified flag is clear, req_o drops one cycle later without any acknowledge.
- R8: While a qualified flag stays set after acknowledge, a new event on it raises no request. After the OR has fallen, a new event raises one again.
- R9: While node_en_i is low, req_o is held at 0, but the edge history keeps tracking the OR. A flag that became qualified while the node was disabled raises no request when the node is enabled again.
- R10: After reset all flags are 0 and req_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | One-cycle event pulses, one per source |
| clr_i | input | NUM_SRC | Software flag clear strobes |
| src_en_i | input | NUM_SRC | Per-source interrupt enables (ignored where the source has none) |
| node_en_i | input | 1 | Node enable |
| ack_i | input | 1 | CPU acknowledge of this node |
| flags_o | output | NUM_SRC | Current source flags |
| req_o | output | 1 | Pending request to the CPU |

## Verification
The hardest situation to reach is a request that is lost without any acknowledge. This happens when a flag becomes qualified while the node is disabled, or when a flag is held set across service, so the OR never falls. The stimulus reaches the first case by raising a flag with node_en_i low and then enabling the node. It reaches the second by acknowledging without clearing and then pulsing the same source again. A further directed step lines up an acknowledge with the cycle in which a fresh rising edge would set the request. A random phase follows, checked cycle by cycle against a behavioural model.

// File: rtl/isr_node_pkg.sv
package isr_node_pkg;

    localparam int unsigned DEF_NUM_SRC = 4;

    typedef struct packed {
        logic pend;
        logic prev;
    } pend_state_t;

endpackage

// File: rtl/isr_flag_bank.sv
module isr_flag_bank #(
    parameter int unsigned NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] flags_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] flags;
    } bank_state_t;

    bank_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (evt_i[i])
                state_d.flags[i] = 1'b1;
            else if (clr_i[i])
                state_d.flags[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign flags_o = state_q.flags;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> flags_o[g]);
        assert_clr_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !evt_i[g]) |=> !flags_o[g]);
    end

endmodule

// File: rtl/isr_qualify.sv
module isr_qualify #(
    parameter int unsigned        NUM_SRC    = 4,
    parameter logic [NUM_SRC-1:0] SRC_HAS_EN = '1
) (
    input  logic [NUM_SRC-1:0] flags_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    output logic               any_o
);

    logic [NUM_SRC-1:0] qual_d;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (SRC_HAS_EN[g]) begin : g_gated
            always_comb qual_d[g] = flags_i[g] & src_en_i[g];
        end else begin : g_free
            always_comb qual_d[g] = flags_i[g];
        end
    end

    always_comb any_o = |qual_d;

endmodule

// File: rtl/isr_pend_ctrl.sv
module isr_pend_ctrl
    import isr_node_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_i,
    input  logic node_en_i,
    input  logic ack_i,
    output logic req_o
);

    pend_state_t state_d, state_q;
    logic        rise_d;

    always_comb begin
        state_d      = state_q;
        rise_d       = any_i & ~state_q.prev;
        state_d.prev = any_i;
        if (!node_en_i || ack_i || !any_i)
            state_d.pend = 1'b0;
        else if (rise_d)
            state_d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign req_o = state_q.pend;

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !req_o);
    assert_node_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !node_en_i |=> !req_o);
    assert_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> $past(any_i && node_en_i));
    assert_idle_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(any_i));

endmodule

// File: rtl/isr_shared_node.sv
module isr_shared_node #(
    parameter int unsigned        NUM_SRC    = isr_node_pkg::DEF_NUM_SRC,
    parameter logic [NUM_SRC-1:0] SRC_HAS_EN = 4'b0011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic               node_en_i,
    input  logic               ack_i,
    output logic [NUM_SRC-1:0] flags_o,
    output logic               req_o
);

    logic any_q;

    isr_flag_bank #(.NUM_SRC(NUM_SRC)) flag_bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .clr_i   (clr_i),
        .flags_o (flags_o)
    );

    isr_qualify #(.NUM_SRC(NUM_SRC), .SRC_HAS_EN(SRC_HAS_EN)) qualify_i (
        .flags_i  (flags_o),
        .src_en_i (src_en_i),
        .any_o    (any_q)
    );

    isr_pend_ctrl pend_ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_i     (any_q),
        .node_en_i (node_en_i),
        .ack_i     (ack_i),
        .req_o     (req_o)
    );

endmodule

// File: tb/isr_shared_node_tb_top.sv
module isr_shared_node_tb_top;

    localparam int       CLK_PERIOD = 10;
    localparam int       N          = 4;
    localparam bit [3:0] HAS_EN     = 4'b0011;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt = '0, clr = '0, src_en = '0;
    logic         node_en = 1'b0, ack = 1'b0;
    logic [N-1:0] flags;
    logic         req;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference
    bit m_flag [N];
    bit m_prev = 0, m_pend = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isr_shared_node #(.NUM_SRC(N), .SRC_HAS_EN(HAS_EN)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(clr), .src_en_i(src_en),
        .node_en_i(node_en), .ack_i(ack), .flags_o(flags), .req_o(req)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_flag[i]) m_flag[i] = 0;
            m_prev = 0; m_pend = 0;
        end else begin
            bit raw;
            raw = 0;
            for (int i = 0; i < N; i++)
                if (m_flag[i] && (!HAS_EN[i] || src_en[i])) raw = 1;
            if (!node_en || ack || !raw) m_pend = 0;
            else if (!m_prev) m_pend = 1;
            m_prev = raw;
            for (int i = 0; i < N; i++)
                if (evt[i]) m_flag[i] = 1;
                else if (clr[i]) m_flag[i] = 0;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [N-1:0] mf;
            for (int i = 0; i < N; i++) mf[i] = m_flag[i];
            check("R1 model flags", int'(flags), int'(mf));
            check("R3 model req", int'(req), int'(m_pend));
        end
    end

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_evt(input int s);
        evt[s] = 1'b1; step(); evt[s] = 1'b0;
    endtask

    task automatic pulse_clr(input int s);
        clr[s] = 1'b1; step(); clr[s] = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        step(2);
        check("R10 reset flags", int'(flags), 0);
        check("R10 reset req", int'(req), 0);
        rst_n = 1'b1;
        node_en = 1'b1;
        src_en = 4'b0001;
        step();

        // R1 / R3
        pulse_evt(0);
        check("R1 flag set", int'(flags), 1);
        check("R3 no req yet", int'(req), 0);
        step();
        check("R3 req raised", int'(req), 1);
        // R6 ack
        ack = 1'b1; step(); ack = 1'b0;
        check("R6 ack clears", int'(req), 0);
        // R8 held flag
        pulse_evt(0); step(2);
        check("R8 held flag no req", int'(req), 0);
        pulse_clr(0);
        check("R2 flag cleared", int'(flags), 0);
        step();
        pulse_evt(0); step();
        check("R8 req after fall", int'(req), 1);
        // R7 clear without ack
        pulse_clr(0); step();
        check("R7 req drops", int'(req), 0);
        // R4 gated source
        pulse_evt(1); step(2);
        check("R4 flag present", int'(flags), 2);
        check("R4 no req", int'(req), 0);
        pulse_clr(1); step();
        // R5 free source
        pulse_evt(2); step();
        check("R5 req from free src", int'(req), 1);
        pulse_clr(2); step(2);
        // R1 set wins
        evt[3] = 1'b1; clr[3] = 1'b1; step(); evt[3] = 1'b0; clr[3] = 1'b0;
        check("R1 set wins over clear", int'(flags), 8);
        step();
        check("R5 req from src3", int'(req), 1);
        pulse_clr(3); step(2);
        // R9 disabled node
        node_en = 1'b0;
        pulse_evt(2); step(3);
        check("R9 req held low", int'(req), 0);
        node_en = 1'b1; step(3);
        check("R9 no edge on enable", int'(req), 0);
        pulse_clr(2); step(2);
        pulse_evt(2); step();
        check("R9 req after new edge", int'(req), 1);
        pulse_clr(2); step(3);
        // R6 ack vs edge
        pulse_evt(0);
        ack = 1'b1; step(); ack = 1'b0;
        check("R6 ack wins over edge", int'(req), 0);
        step();
        check("R6 no late req", int'(req), 0);
        pulse_clr(0); step(2);

        // random phase against the model
        for (int k = 0; k < 2000; k++) begin
            evt     = N'($urandom_range(0, 15)) & N'($urandom_range(0, 15));
            clr     = N'($urandom_range(0, 15)) & N'($urandom_range(0, 15));
            if ($urandom_range(0, 7) == 0) src_en = N'($urandom_range(0, 15));
            if ($urandom_range(0, 15) == 0) node_en = ~node_en;
            ack     = ($urandom_range(0, 5) == 0);
            step();
        end
        evt = '0; clr = '0; ack = 1'b0;
        step(2);
        finish_run();
    end

endmodule